// File: doc/BRIEF.md
# Dual-Mode Internal Data Memory

This block is the 256-byte internal scratch memory of an 8-bit microcontroller core. The core issues at most one request per cycle. Each request names an access kind, an operation and an 8-bit operand. The access kind sets how the operand is read:

- a direct byte address;
- an indirect pointer;
- a working-register number resolved against a 2-bit bank select;
- a single-bit address.

The addressing mode, not the address value alone, decides where locations at or above 0x80 go. Indirect requests reach the upper half of the RAM. Direct requests in that range go to a separate port for the function-register space, which lives outside this block.

A window of sixteen bytes starting at 0x20 can also be reached one bit at a time. A bit store is done as a read-modify-write of the containing byte within the single access cycle. Every request serviced by the RAM returns, one clock later, the byte value as it was before that request. Requests routed to the function-register port come out one clock later as a registered strobe with the operand fields.

Top module: `iram_dual_mode`

## Requirements
- R1: An indirect request (kind 1) reaches RAM byte equal to the pointer for every value 0x00–0xFF. Op WRITE (1) stores `req_wdata` there.
- R2: A direct request (kind 0) with address below 0x80 reaches the same RAM byte that an indirect request with that value reaches.
- R3: A direct request with address 0x80–0xFF never touches RAM and raises no read response. One cycle later it appears on the function-register port with `sfr_req`=1, `sfr_bit`=0, and the request's op, address and write data.
- R4: A working-register request (kind 2) for register n = `req_addr[2:0]` reaches byte `bank_sel`*8 + n. The bank is taken from `bank_sel` in the same cycle as each request.
- R5: A bit request (kind 3) with bit address below 0x80 reaches byte 0x20 + `req_addr[6:3]`, bit position `req_addr[2:0]`. The ops are READ=0, WRITE=1 (store `req_wbit`), SET=2 and CLR=3.
- R6: A bit WRITE, SET or CLR changes only the addressed bit of the containing byte.
- R7: A bit request with bit address 0x80–0xFF never touches RAM. One cycle later it appears on the port with `sfr_req`=1, `sfr_bit`=1, and the op, address and `req_wbit`.
- R8: Every RAM-serviced request raises `rd_valid` in the next cycle. `rd_data` then holds the byte value before the request, so a write returns the old value. `rd_bit` holds the old addressed bit for bit requests and 0 for byte requests.
- R9: For byte-wide requests (kinds 0, 1 and 2), only op WRITE stores. Ops READ, SET and CLR leave the byte unchanged.
- R10: While `rst_n` is low, requests are ignored, and in the next cycle `rd_valid`, `rd_data`, `rd_bit` and all `sfr_*` outputs are 0. RAM contents survive reset.
- R11: `rd_valid` and `sfr_req` are never high together. Both are 0 in the cycle after a cycle with `req_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 direct, 1 indirect, 2 working register, 3 bit |
| req_op | input | 2 | 0 READ, 1 WRITE, 2 SET, 3 CLR |
| req_addr | input | 8 | Address, pointer, register number or bit address |
| req_wdata | input | 8 | Byte write data |
| req_wbit | input | 1 | Bit write value |
| bank_sel | input | 2 | Working-register bank |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Byte value before the request |
| rd_bit | output | 1 | Addressed bit value before the request |
| sfr_req | output | 1 | Function-register request strobe |
| sfr_bit | output | 1 | Forwarded request is a bit operation |
| sfr_op | output | 2 | Forwarded op |
| sfr_addr | output | 8 | Forwarded address or bit address |
| sfr_wdata | output | 8 | Forwarded byte write data |
| sfr_wbit | output | 1 | Forwarded bit write value |

## Verification
Some properties are checked on every cycle:

- which output responds to each kind of request (RAM response or function-register strobe);
- that the two responses never overlap;
- that a bit store flips at most one bit;
- that a byte WRITE lands in the array.

The remaining behaviour can only be shown through the bench's scenarios against its reference array. This covers the actual data returned, the bank-to-address mapping, the bit-window arithmetic, and the fact that a direct write above 0x7F leaves the upper RAM byte untouched. It also covers RAM contents surviving a reset.

// File: rtl/iram_pkg.sv
// Package iram_pkg
// Shared encodings for the internal data memory: access kinds and operations.
// Assumes a single request per cycle from the core.
package iram_pkg;
    typedef enum logic [1:0] {
        ACC_DIRECT   = 2'd0,
        ACC_INDIRECT = 2'd1,
        ACC_WREG     = 2'd2,
        ACC_BIT      = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLR   = 2'd3
    } acc_op_e;
endpackage

// File: rtl/iram_route.sv
// Module iram_route
// Combinational address router. Turns (kind, operand, bank) into either a
// RAM byte index plus bit position, or a hit on the function-register port.
// Assumes power-of-two bank and register counts and that the bit window
// fits below the upper half of the array.
module iram_route
    import iram_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int BANKS    = 4,
    parameter int REGS     = 8,
    parameter int BIT_BASE = 32
) (
    input  logic                       go,
    input  acc_kind_e                  kind,
    input  logic [ADDR_W-1:0]          operand,
    input  logic [$clog2(BANKS)-1:0]   bank,
    output logic                       ram_hit,
    output logic                       sfr_hit,
    output logic                       bit_acc,
    output logic [ADDR_W-1:0]          ram_idx,
    output logic [$clog2(DATA_W)-1:0]  bit_pos
);
    localparam int BPOS_W = $clog2(DATA_W);
    localparam int REG_W  = $clog2(REGS);
    localparam logic [ADDR_W-1:0] BIT_BASE_V = BIT_BASE[ADDR_W-1:0];

    logic upper;
    assign upper = operand[ADDR_W-1];

    // Decode the request into a destination and an array index.
    always_comb begin
        ram_hit = 1'b0;
        sfr_hit = 1'b0;
        bit_acc = 1'b0;
        ram_idx = operand;
        bit_pos = operand[BPOS_W-1:0];
        case (kind)
            ACC_DIRECT: begin
                ram_hit = go & ~upper;
                sfr_hit = go & upper;
            end
            ACC_INDIRECT: begin
                ram_hit = go;
            end
            ACC_WREG: begin
                ram_hit = go;
                ram_idx = ADDR_W'({bank, operand[REG_W-1:0]});
            end
            default: begin
                bit_acc = 1'b1;
                ram_hit = go & ~upper;
                sfr_hit = go & upper;
                ram_idx = BIT_BASE_V + ADDR_W'(operand[ADDR_W-2:BPOS_W]);
            end
        endcase
    end
endmodule

// File: rtl/iram_store.sv
// Module iram_store
// Byte array with a registered read port. A bit operation does a
// read-modify-write of the addressed byte in the same cycle. Every serviced
// access returns the pre-access byte one cycle later. The array itself is
// not reset; only the response registers are.
module iram_store
    import iram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_en,
    input  logic [ADDR_W-1:0]          idx,
    input  logic                       bit_acc,
    input  logic [$clog2(DATA_W)-1:0]  bit_pos,
    input  acc_op_e                    op,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       wbit,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_bit
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BPOS_W = $clog2(DATA_W);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] old_byte;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] new_byte;
    logic              old_bit;
    logic              new_bit;
    logic              wr_en;

    assign old_byte = mem[idx];
    assign old_bit  = old_byte[bit_pos];

    // Pick the new value of the addressed bit for a bit operation.
    always_comb begin
        case (op)
            OP_WRITE: new_bit = wbit;
            OP_SET:   new_bit = 1'b1;
            OP_CLR:   new_bit = 1'b0;
            default:  new_bit = old_bit;
        endcase
    end

    // One lane per bit: replace only the addressed lane.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign merged[g] = (bit_pos == BPOS_W'(g)) ? new_bit : old_byte[g];
    end

    assign new_byte = bit_acc ? merged : wdata;
    assign wr_en    = acc_en & (bit_acc ? (op != OP_READ) : (op == OP_WRITE));

    // Array write; contents are kept across reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= new_byte;
        end
    end

    // Registered response carrying the pre-access value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= acc_en;
            rd_data  <= acc_en ? old_byte : '0;
            rd_bit   <= acc_en & bit_acc & old_bit;
        end
    end

    // A bit store alters at most one bit of the stored byte.
    assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && bit_acc && op != OP_READ)
            |=> ($countones(mem[$past(idx)] ^ $past(old_byte)) <= 1));

    // A byte WRITE lands in the array.
    assert_byte_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !bit_acc && op == OP_WRITE)
            |=> (mem[$past(idx)] == $past(wdata)));

    // Byte READ, SET and CLR leave the byte unchanged.
    assert_byte_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !bit_acc && op != OP_WRITE)
            |=> (mem[$past(idx)] == $past(old_byte)));
endmodule

// File: rtl/iram_sfr_port.sv
// Module iram_sfr_port
// Registers requests bound for the function-register space and presents
// them one cycle later as a strobe with the operand fields. Assumes the
// function-register block accepts one request per cycle.
module iram_sfr_port
    import iram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic               bit_acc,
    input  acc_op_e            op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               wbit,
    output logic               sfr_req,
    output logic               sfr_bit,
    output logic [1:0]         sfr_op,
    output logic [ADDR_W-1:0]  sfr_addr,
    output logic [DATA_W-1:0]  sfr_wdata,
    output logic               sfr_wbit
);
    // Capture a forwarded request; clear all fields otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !hit) begin
            sfr_req   <= 1'b0;
            sfr_bit   <= 1'b0;
            sfr_op    <= 2'b00;
            sfr_addr  <= '0;
            sfr_wdata <= '0;
            sfr_wbit  <= 1'b0;
        end else begin
            sfr_req   <= 1'b1;
            sfr_bit   <= bit_acc;
            sfr_op    <= op;
            sfr_addr  <= addr;
            sfr_wdata <= bit_acc ? '0 : wdata;
            sfr_wbit  <= bit_acc & wbit;
        end
    end

    // The strobe is only raised for a forwarded request.
    assert_strobe_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !sfr_req);
endmodule

// File: rtl/iram_dual_mode.sv
// Module iram_dual_mode (top)
// Internal data memory with direct, indirect, working-register and bit
// access. Upper addresses reach RAM only by indirect access; direct and bit
// accesses there go to the function-register port. Assumes one request per
// cycle and a synchronous active-low reset.
module iram_dual_mode
    import iram_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int BANKS    = 4,
    parameter int REGS     = 8,
    parameter int BIT_BASE = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [1:0]                req_kind,
    input  logic [1:0]                req_op,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic                      req_wbit,
    input  logic [$clog2(BANKS)-1:0]  bank_sel,
    output logic                      rd_valid,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      rd_bit,
    output logic                      sfr_req,
    output logic                      sfr_bit,
    output logic [1:0]                sfr_op,
    output logic [ADDR_W-1:0]         sfr_addr,
    output logic [DATA_W-1:0]         sfr_wdata,
    output logic                      sfr_wbit
);
    localparam int BPOS_W = $clog2(DATA_W);

    acc_kind_e          kind;
    acc_op_e            op;
    logic               go;
    logic               ram_hit;
    logic               sfr_hit;
    logic               bit_acc;
    logic [ADDR_W-1:0]  ram_idx;
    logic [BPOS_W-1:0]  bit_pos;

    assign kind = acc_kind_e'(req_kind);
    assign op   = acc_op_e'(req_op);
    assign go   = req_valid & rst_n;

    iram_route #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANKS(BANKS),
        .REGS(REGS), .BIT_BASE(BIT_BASE)
    ) u_route (
        .go(go), .kind(kind), .operand(req_addr), .bank(bank_sel),
        .ram_hit(ram_hit), .sfr_hit(sfr_hit), .bit_acc(bit_acc),
        .ram_idx(ram_idx), .bit_pos(bit_pos)
    );

    iram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .acc_en(ram_hit), .idx(ram_idx),
        .bit_acc(bit_acc), .bit_pos(bit_pos), .op(op),
        .wdata(req_wdata), .wbit(req_wbit),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit)
    );

    iram_sfr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sfr (
        .clk(clk), .rst_n(rst_n), .hit(sfr_hit), .bit_acc(bit_acc), .op(op),
        .addr(req_addr), .wdata(req_wdata), .wbit(req_wbit),
        .sfr_req(sfr_req), .sfr_bit(sfr_bit), .sfr_op(sfr_op),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_wbit(sfr_wbit)
    );

    // An indirect request is always answered by the RAM.
    assert_indirect_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (rd_valid && !sfr_req));

    // A direct request in the lower half is answered by the RAM.
    assert_direct_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0 && !req_addr[ADDR_W-1]) |=> (rd_valid && !sfr_req));

    // A direct request in the upper half goes out as a byte strobe only.
    assert_direct_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0 && req_addr[ADDR_W-1])
            |=> (sfr_req && !sfr_bit && !rd_valid));

    // A working-register request is answered by the RAM.
    assert_wreg_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> (rd_valid && !sfr_req));

    // An upper bit address goes out as a bit strobe.
    assert_bit_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3 && req_addr[ADDR_W-1])
            |=> (sfr_req && sfr_bit && !rd_valid));

    // The two response paths never fire together.
    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, sfr_req}));

    // No response follows an idle cycle.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rd_valid && !sfr_req));
endmodule

// File: tb/sim_iram_dual_mode.sv
`timescale 1ns/1ps
module sim_iram_dual_mode;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_addr = 8'h00;
    logic [7:0] req_wdata = 8'h00;
    logic       req_wbit = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_bit;
    logic       sfr_req;
    logic       sfr_bit;
    logic [1:0] sfr_op;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic       sfr_wbit;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [256];
    bit done = 1'b0;

    always #4 clk = ~clk;

    iram_dual_mode u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wbit(req_wbit), .bank_sel(bank_sel),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
        .sfr_req(sfr_req), .sfr_bit(sfr_bit), .sfr_op(sfr_op),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_wbit(sfr_wbit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // RAM index for a request, following R1/R2/R4/R5
    function automatic logic [7:0] ref_idx(input logic [1:0] k, input logic [7:0] a,
                                           input logic [1:0] bk);
        case (k)
            2'd2:    return {3'b000, bk, a[2:0]};
            2'd3:    return 8'h20 + {4'h0, a[6:3]};
            default: return a;
        endcase
    endfunction

    function automatic bit ref_is_ram(input logic [1:0] k, input logic [7:0] a);
        return (k == 2'd1 || k == 2'd2) ? 1'b1 : !a[7];
    endfunction

    // One request: drive, wait one cycle, compare with model, update model
    task automatic access(input logic [1:0] k, input logic [1:0] o, input logic [7:0] a,
                          input logic [7:0] wd, input logic wb, input logic [1:0] bk,
                          input string req);
        logic [7:0] idx;
        logic [7:0] old;
        bit ram;
        req_valid = 1'b1; req_kind = k; req_op = o; req_addr = a;
        req_wdata = wd; req_wbit = wb; bank_sel = bk;
        @(negedge clk);
        req_valid = 1'b0;
        ram = ref_is_ram(k, a);
        idx = ref_idx(k, a, bk);
        old = ref_mem[idx];
        if (ram) begin
            chk(rd_valid == 1'b1 && sfr_req == 1'b0, req, "ram route", {rd_valid, sfr_req}, 2'b10);
            chk(rd_data == old, req, "rd_data old", rd_data, old);
            chk(rd_bit == ((k == 2'd3) ? old[a[2:0]] : 1'b0), req, "rd_bit", rd_bit,
                (k == 2'd3) ? old[a[2:0]] : 1'b0);
            if (k == 2'd3) begin
                case (o)
                    2'd1: ref_mem[idx][a[2:0]] = wb;
                    2'd2: ref_mem[idx][a[2:0]] = 1'b1;
                    2'd3: ref_mem[idx][a[2:0]] = 1'b0;
                    default: ;
                endcase
            end else if (o == 2'd1) begin
                ref_mem[idx] = wd;
            end
        end else begin
            chk(rd_valid == 1'b0 && sfr_req == 1'b1, req, "sfr route", {rd_valid, sfr_req}, 2'b01);
            chk(sfr_bit == (k == 2'd3) && sfr_op == o && sfr_addr == a, req, "sfr fields",
                {sfr_bit, sfr_op, sfr_addr}, {(k == 2'd3), o, a});
            if (k == 2'd3) chk(sfr_wbit == wb, req, "sfr_wbit", sfr_wbit, wb);
            else           chk(sfr_wdata == wd, req, "sfr_wdata", sfr_wdata, wd);
        end
    endtask

    task automatic check_quiet(input string req);
        chk(!rd_valid && !sfr_req && rd_data == 8'h00 && !rd_bit && !sfr_bit &&
            sfr_op == 2'd0 && sfr_addr == 8'h00 && sfr_wdata == 8'h00 && !sfr_wbit,
            req, "outputs cleared", {rd_valid, sfr_req, rd_data}, 0);
    endtask

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check_quiet("R10");                      // reset state
        rst_n = 1'b1;
        @(negedge clk);
        // R1: fill every byte indirectly
        for (int i = 0; i < 256; i++) access(2'd1, 2'd1, i[7:0], 8'(i * 7 + 3), 1'b0, 2'd0, "R1");
        for (int i = 0; i < 256; i += 37) access(2'd1, 2'd0, i[7:0], 8'h00, 1'b0, 2'd0, "R1");
        // R2: direct low half aliases indirect
        access(2'd0, 2'd1, 8'h45, 8'h5A, 1'b0, 2'd0, "R2");
        access(2'd1, 2'd0, 8'h45, 8'h00, 1'b0, 2'd0, "R2");
        access(2'd0, 2'd0, 8'h7F, 8'h00, 1'b0, 2'd0, "R2");
        // R3: direct write above 0x7F leaves upper RAM untouched
        access(2'd0, 2'd1, 8'h90, 8'hC3, 1'b0, 2'd0, "R3");
        access(2'd1, 2'd0, 8'h90, 8'h00, 1'b0, 2'd0, "R3");
        access(2'd0, 2'd0, 8'h80, 8'h11, 1'b0, 2'd0, "R3");
        // R4: each bank maps register 3 and 7 to bank*8+n
        for (int b = 0; b < 4; b++) begin
            access(2'd2, 2'd1, 8'hF3, 8'(8'hA0 + b), 1'b0, b[1:0], "R4");
            access(2'd1, 2'd0, 8'(b * 8 + 3), 8'h00, 1'b0, 2'd0, "R4");
            access(2'd2, 2'd0, 8'h07, 8'h00, 1'b0, b[1:0], "R4");
        end
        // R5/R6: bit window edges and all ops
        access(2'd3, 2'd2, 8'h00, 8'h00, 1'b0, 2'd0, "R5");
        access(2'd3, 2'd3, 8'h7F, 8'h00, 1'b0, 2'd0, "R5");
        access(2'd1, 2'd0, 8'h20, 8'h00, 1'b0, 2'd0, "R6");
        access(2'd1, 2'd0, 8'h2F, 8'h00, 1'b0, 2'd0, "R6");
        access(2'd3, 2'd1, 8'h3A, 8'h00, 1'b1, 2'd0, "R5");
        access(2'd3, 2'd0, 8'h3A, 8'h00, 1'b0, 2'd0, "R5");
        access(2'd1, 2'd0, 8'h27, 8'h00, 1'b0, 2'd0, "R6");
        // R7: upper bit addresses go to the port
        access(2'd3, 2'd1, 8'hE5, 8'h00, 1'b1, 2'd0, "R7");
        access(2'd3, 2'd3, 8'h80, 8'h00, 1'b0, 2'd0, "R7");
        // R8: write returns old value, then new value is visible
        access(2'd1, 2'd1, 8'hC0, 8'h3C, 1'b0, 2'd0, "R8");
        access(2'd1, 2'd0, 8'hC0, 8'h00, 1'b0, 2'd0, "R8");
        // R9: byte SET/CLR do not store
        access(2'd1, 2'd2, 8'hC0, 8'hFF, 1'b0, 2'd0, "R9");
        access(2'd0, 2'd3, 8'h10, 8'hFF, 1'b0, 2'd0, "R9");
        access(2'd1, 2'd0, 8'hC0, 8'h00, 1'b0, 2'd0, "R9");
        access(2'd1, 2'd0, 8'h10, 8'h00, 1'b0, 2'd0, "R9");
        // R11: idle cycle gives no response
        @(negedge clk);
        chk(!rd_valid && !sfr_req, "R11", "idle", {rd_valid, sfr_req}, 2'b00);
        // R10: request during reset ignored, RAM kept
        rst_n = 1'b0;
        req_valid = 1'b1; req_kind = 2'd1; req_op = 2'd1; req_addr = 8'h05; req_wdata = 8'hEE;
        @(negedge clk);
        req_valid = 1'b0;
        check_quiet("R10");
        rst_n = 1'b1;
        @(negedge clk);
        access(2'd1, 2'd0, 8'h05, 8'h00, 1'b0, 2'd0, "R10");
        access(2'd1, 2'd0, 8'hFF, 8'h00, 1'b0, 2'd0, "R10");
        // Random mix (R1-related kinds across all ops)
        for (int n = 0; n < 600; n++) begin
            access(2'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                   2'($urandom), "R8");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule